// File: doc/BRIEF.md
# Strided Two-Dimensional Transfer Address Generator

This block produces the address stream for one rectangular memory transfer inside a DMA or blit engine. A source and a destination walker each start at a base address and advance one beat at a time. After `line_len` bytes, each walker jumps to its own line start plus its own stride. A line length of zero turns both walkers into flat contiguous counters and ignores both strides. The transfer ends when `total` bytes have been issued.

Each side can move its start address by two fixed offsets, one added and one subtracted. Each side has its own enable bit for this. Offsets keep only bits 21 down to 4, so they are always whole 16-byte units.

A start pulse on an idle generator samples the whole configuration. An illegal setup raises an error flag instead of starting. Beats leave on a plain valid/ready pair, with one source and one destination address per beat.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, `busy`, `beat_valid`, `done` and `cfg_err` are all low.
- R2: A `start` seen while idle with a legal setup raises `busy` and `beat_valid` in the next cycle. The first beat then carries the two (offset-adjusted) start addresses.
- R3: Inside a line, each accepted beat (`beat_valid` and `beat_ready` high at a clock edge) advances both addresses by 4 bytes.
- R4: After `line_len` bytes of a line have been accepted, each side's next address is that line's first address plus that side's own stride.
- R5: With `line_len` = 0, addresses run contiguously in 4-byte steps and both strides have no effect.
- R6: With a side's offset enable set, that side starts at base + (pos & 0x3FFFF0) − (neg & 0x3FFFF0), modulo 2^32. Offset bits outside 21:4 have no effect, and a side with its enable clear starts at its base.
- R7: Exactly `total`/4 beats are issued. `done` is high for one cycle, in the cycle after the last beat is accepted, and `busy` drops in that same cycle.
- R8: `start` while idle raises `cfg_err` in the next cycle and issues no beat when any of these holds:
  - `total` is zero or not a multiple of 4;
  - `line_len` is not a multiple of 4;
  - with `line_len` nonzero, either stride is not a multiple of 4 or is smaller than `line_len`.
- R9: `cfg_err` stays high until the next `start` with a legal setup. While `busy` is high, `start` and every configuration input have no effect on the addresses issued.
- R10: While `beat_valid` is high and `beat_ready` is low, `beat_valid` and both addresses hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (honoured only while idle) |
| cfg_src_base | input | 32 | Source base address |
| cfg_dst_base | input | 32 | Destination base address |
| cfg_line_len | input | 12 | Bytes per line; 0 selects flat addressing |
| cfg_src_stride | input | 16 | Source distance between line starts, bytes |
| cfg_dst_stride | input | 16 | Destination distance between line starts, bytes |
| cfg_total | input | 24 | Total bytes to transfer |
| cfg_pos_ofs | input | 32 | Added offset, bits 21:4 used |
| cfg_neg_ofs | input | 32 | Subtracted offset, bits 21:4 used |
| cfg_src_ofs_en | input | 1 | Apply offsets to the source start |
| cfg_dst_ofs_en | input | 1 | Apply offsets to the destination start |
| beat_ready | input | 1 | Memory port accepts the current beat |
| beat_valid | output | 1 | Current beat addresses are valid |
| beat_src_addr | output | 32 | Source address of the current beat |
| beat_dst_addr | output | 32 | Destination address of the current beat |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after the final beat |
| cfg_err | output | 1 | Last start attempt had an illegal setup |

## Verification
A start sampled at edge N yields `busy` and the first beat addresses, or `cfg_err`, one cycle later. The bench therefore drives `start` at a falling edge and reads the result at the next falling edge. Each address pair is compared when `beat_valid` and `beat_ready` are both high at a falling edge, because that beat is accepted at the rising edge that follows. From the same falling-edge sample, the bench expects `done` exactly one falling edge after the final accepted beat and nowhere earlier. A stall is checked by comparing the held addresses one falling edge after `beat_ready` was low.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } gen_state_e;
endpackage

// File: rtl/dma2d_cfg_check.sv
module dma2d_cfg_check #(
   parameter int LEN_W      = 12,
   parameter int STR_W      = 16,
   parameter int CNT_W      = 24,
   parameter int BEAT_BYTES = 4
) (
   input  logic [LEN_W-1:0] line_len,
   input  logic [STR_W-1:0] src_stride,
   input  logic [STR_W-1:0] dst_stride,
   input  logic [CNT_W-1:0] total,
   output logic             bad
);
   localparam int BEAT_LSB = $clog2(BEAT_BYTES);

   logic [STR_W-1:0] len_ext;
   logic             len_zero, mis_len, mis_tot, mis_str, too_long;

   assign len_ext  = STR_W'(line_len);
   assign len_zero = (line_len == '0);
   assign mis_len  = |line_len[BEAT_LSB-1:0];
   assign mis_tot  = |total[BEAT_LSB-1:0];
   assign mis_str  = |src_stride[BEAT_LSB-1:0] | |dst_stride[BEAT_LSB-1:0];
   assign too_long = (len_ext > src_stride) | (len_ext > dst_stride);

   always_comb begin
      bad = (total == '0) | mis_tot | mis_len;
      if (!len_zero) bad = bad | mis_str | too_long;
   end
endmodule

// File: rtl/dma2d_walker.sv
module dma2d_walker #(
   parameter int ADDR_W     = 32,
   parameter int STR_W      = 16,
   parameter int BEAT_BYTES = 4,
   parameter int OFS_LSB    = 4,
   parameter int OFS_MSB    = 21,
   parameter bit HAS_OFS    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] base,
   input  logic              ofs_en,
   input  logic [ADDR_W-1:0] pos_ofs,
   input  logic [ADDR_W-1:0] neg_ofs,
   input  logic [STR_W-1:0]  stride,
   input  logic              step,
   input  logic              line_end,
   output logic [ADDR_W-1:0] addr
);
   localparam logic [ADDR_W-1:0] OFS_MASK =
      (ADDR_W'(1) << (OFS_MSB + 1)) - (ADDR_W'(1) << OFS_LSB);
   localparam logic [ADDR_W-1:0] A_BEAT = ADDR_W'(BEAT_BYTES);

   logic [ADDR_W-1:0] start_addr, line_q, cur_q, stride_q, next_line;

   generate
      if (HAS_OFS) begin : g_ofs
         logic [ADDR_W-1:0] delta;
         assign delta      = (pos_ofs & OFS_MASK) - (neg_ofs & OFS_MASK);
         assign start_addr = ofs_en ? base + delta : base;
      end else begin : g_no_ofs
         logic unused_ofs;
         assign unused_ofs = ofs_en ^ (^pos_ofs) ^ (^neg_ofs);
         assign start_addr = base;
      end
   endgenerate

   assign next_line = line_q + stride_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q   <= '0;
         cur_q    <= '0;
         stride_q <= '0;
      end else if (load) begin
         line_q   <= start_addr;
         cur_q    <= start_addr;
         stride_q <= ADDR_W'(stride);
      end else if (step) begin
         if (line_end) begin
            line_q <= next_line;
            cur_q  <= next_line;
         end else begin
            cur_q <= cur_q + A_BEAT;
         end
      end
   end

   assign addr = cur_q;

   a_r3_beat_step: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !line_end && !load) |=> (addr == $past(addr) + A_BEAT));
endmodule

// File: rtl/dma2d_seq.sv
module dma2d_seq
   import dma2d_pkg::*;
#(
   parameter int LEN_W      = 12,
   parameter int CNT_W      = 24,
   parameter int BEAT_BYTES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             cfg_bad,
   input  logic [LEN_W-1:0] line_len,
   input  logic [CNT_W-1:0] total,
   input  logic             ready,
   output logic             busy,
   output logic             done,
   output logic             err,
   output logic             load,
   output logic             step,
   output logic             line_end
);
   localparam logic [LEN_W-1:0] L_BEAT = LEN_W'(BEAT_BYTES);
   localparam logic [CNT_W-1:0] C_BEAT = CNT_W'(BEAT_BYTES);

   gen_state_e       st_q;
   logic [CNT_W-1:0] remain_q;
   logic [LEN_W-1:0] pos_q, len_q;
   logic             done_q, err_q, accept, last;

   assign busy     = (st_q == ST_RUN);
   assign accept   = start & ~busy;
   assign load     = accept & ~cfg_bad;
   assign step     = busy & ready;
   assign last     = (remain_q == C_BEAT);
   assign line_end = busy && (len_q != '0) && ((pos_q + L_BEAT) == len_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         remain_q <= '0;
         pos_q    <= '0;
         len_q    <= '0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            err_q <= cfg_bad;
            if (!cfg_bad) begin
               st_q     <= ST_RUN;
               remain_q <= total;
               pos_q    <= '0;
               len_q    <= line_len;
            end
         end else if (step) begin
            remain_q <= remain_q - C_BEAT;
            pos_q    <= (line_end || len_q == '0) ? '0 : pos_q + L_BEAT;
            if (last) begin
               st_q   <= ST_IDLE;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign done = done_q;
   assign err  = err_q;

   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r7_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ($past(step) && !busy));
   a_r8_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !busy);
   a_r9_busy_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !(step && last)) |=> busy);
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen #(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 12,
   parameter int STR_W      = 16,
   parameter int CNT_W      = 24,
   parameter int BEAT_BYTES = 4,
   parameter int OFS_LSB    = 4,
   parameter int OFS_MSB    = 21,
   parameter bit HAS_OFS    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] cfg_src_base,
   input  logic [ADDR_W-1:0] cfg_dst_base,
   input  logic [LEN_W-1:0]  cfg_line_len,
   input  logic [STR_W-1:0]  cfg_src_stride,
   input  logic [STR_W-1:0]  cfg_dst_stride,
   input  logic [CNT_W-1:0]  cfg_total,
   input  logic [ADDR_W-1:0] cfg_pos_ofs,
   input  logic [ADDR_W-1:0] cfg_neg_ofs,
   input  logic              cfg_src_ofs_en,
   input  logic              cfg_dst_ofs_en,
   input  logic              beat_ready,
   output logic              beat_valid,
   output logic [ADDR_W-1:0] beat_src_addr,
   output logic [ADDR_W-1:0] beat_dst_addr,
   output logic              busy,
   output logic              done,
   output logic              cfg_err
);
   generate
      if (STR_W < LEN_W) begin : g_chk_str
         $error("STR_W must not be narrower than LEN_W");
      end
      if (BEAT_BYTES < 2 || (BEAT_BYTES & (BEAT_BYTES - 1)) != 0) begin : g_chk_beat
         $error("BEAT_BYTES must be a power of two, at least 2");
      end
      if (OFS_MSB >= ADDR_W - 1 || OFS_LSB > OFS_MSB) begin : g_chk_ofs
         $error("offset field must lie inside the address");
      end
   endgenerate

   logic cfg_bad, load, step, line_end;

   dma2d_cfg_check #(
      .LEN_W(LEN_W), .STR_W(STR_W), .CNT_W(CNT_W), .BEAT_BYTES(BEAT_BYTES)
   ) u_check (
      .line_len  (cfg_line_len),
      .src_stride(cfg_src_stride),
      .dst_stride(cfg_dst_stride),
      .total     (cfg_total),
      .bad       (cfg_bad)
   );

   dma2d_seq #(
      .LEN_W(LEN_W), .CNT_W(CNT_W), .BEAT_BYTES(BEAT_BYTES)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .cfg_bad (cfg_bad),
      .line_len(cfg_line_len),
      .total   (cfg_total),
      .ready   (beat_ready),
      .busy    (busy),
      .done    (done),
      .err     (cfg_err),
      .load    (load),
      .step    (step),
      .line_end(line_end)
   );

   dma2d_walker #(
      .ADDR_W(ADDR_W), .STR_W(STR_W), .BEAT_BYTES(BEAT_BYTES),
      .OFS_LSB(OFS_LSB), .OFS_MSB(OFS_MSB), .HAS_OFS(HAS_OFS)
   ) u_src (
      .clk(clk), .rst_n(rst_n), .load(load), .base(cfg_src_base),
      .ofs_en(cfg_src_ofs_en), .pos_ofs(cfg_pos_ofs), .neg_ofs(cfg_neg_ofs),
      .stride(cfg_src_stride), .step(step), .line_end(line_end),
      .addr(beat_src_addr)
   );

   dma2d_walker #(
      .ADDR_W(ADDR_W), .STR_W(STR_W), .BEAT_BYTES(BEAT_BYTES),
      .OFS_LSB(OFS_LSB), .OFS_MSB(OFS_MSB), .HAS_OFS(HAS_OFS)
   ) u_dst (
      .clk(clk), .rst_n(rst_n), .load(load), .base(cfg_dst_base),
      .ofs_en(cfg_dst_ofs_en), .pos_ofs(cfg_pos_ofs), .neg_ofs(cfg_neg_ofs),
      .stride(cfg_dst_stride), .step(step), .line_end(line_end),
      .addr(beat_dst_addr)
   );

   assign beat_valid = busy;

   a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && !beat_ready) |=>
         (beat_valid && $stable(beat_src_addr) && $stable(beat_dst_addr)));
   a_r8_err_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !beat_valid);
endmodule

// File: tb/sim_dma2d_addr_gen.sv
module sim_dma2d_addr_gen;
   localparam logic [31:0] MASK = 32'h003F_FFF0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] cfg_src_base = '0, cfg_dst_base = '0;
   logic [11:0] cfg_line_len = '0;
   logic [15:0] cfg_src_stride = '0, cfg_dst_stride = '0;
   logic [23:0] cfg_total = '0;
   logic [31:0] cfg_pos_ofs = '0, cfg_neg_ofs = '0;
   logic        cfg_src_ofs_en = 1'b0, cfg_dst_ofs_en = 1'b0;
   logic        beat_ready = 1'b0;
   logic        beat_valid, busy, done, cfg_err;
   logic [31:0] beat_src_addr, beat_dst_addr;

   int          n_chk = 0;
   int          n_err = 0;
   logic [7:0]  lfsr = 8'hA5;

   always #10 clk = ~clk;

   dma2d_addr_gen u0 (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cfg_src_base(cfg_src_base), .cfg_dst_base(cfg_dst_base),
      .cfg_line_len(cfg_line_len), .cfg_src_stride(cfg_src_stride),
      .cfg_dst_stride(cfg_dst_stride), .cfg_total(cfg_total),
      .cfg_pos_ofs(cfg_pos_ofs), .cfg_neg_ofs(cfg_neg_ofs),
      .cfg_src_ofs_en(cfg_src_ofs_en), .cfg_dst_ofs_en(cfg_dst_ofs_en),
      .beat_ready(beat_ready), .beat_valid(beat_valid),
      .beat_src_addr(beat_src_addr), .beat_dst_addr(beat_dst_addr),
      .busy(busy), .done(done), .cfg_err(cfg_err)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_addr(input logic [31:0] st, input int len,
                                            input int stride, input int idx);
      int b;
      b = idx * 4;
      if (len == 0) return st + 32'(b);
      return st + 32'((b / len) * stride + (b % len));
   endfunction

   task automatic run_cfg(input logic [31:0] sb, input logic [31:0] db,
                          input int len, input int ss, input int ds,
                          input int total, input logic se, input logic de,
                          input bit want_err);
      logic [31:0] s0, d0, ps, pd;
      int idx, guard, beats;
      bit held, poked;
      string tag;
      s0 = se ? sb + (cfg_pos_ofs & MASK) - (cfg_neg_ofs & MASK) : sb;
      d0 = de ? db + (cfg_pos_ofs & MASK) - (cfg_neg_ofs & MASK) : db;
      @(negedge clk);
      cfg_src_base = sb; cfg_dst_base = db; cfg_line_len = 12'(len);
      cfg_src_stride = 16'(ss); cfg_dst_stride = 16'(ds); cfg_total = 24'(total);
      cfg_src_ofs_en = se; cfg_dst_ofs_en = de; beat_ready = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (want_err) begin
         chk(cfg_err === 1'b1, "R8 err raised", 32'(cfg_err), 32'd1);
         chk(busy === 1'b0, "R8 not busy", 32'(busy), 32'd0);
         for (int k = 0; k < 3; k++) begin
            beat_ready = 1'b1;
            @(negedge clk);
            chk(beat_valid === 1'b0, "R8 no beat", 32'(beat_valid), 32'd0);
         end
         beat_ready = 1'b0;
         return;
      end
      chk(cfg_err === 1'b0, "R9 err cleared", 32'(cfg_err), 32'd0);
      chk(busy === 1'b1, "R2 busy", 32'(busy), 32'd1);
      beats = total / 4; idx = 0; guard = 0; held = 0; poked = 0;
      ps = '0; pd = '0;
      while (idx < beats && guard < 2000) begin
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         beat_ready = lfsr[0] | lfsr[3];
         chk(beat_valid === 1'b1, "R2 valid", 32'(beat_valid), 32'd1);
         if (held) begin
            chk(beat_src_addr === ps, "R10 src hold", beat_src_addr, ps);
            chk(beat_dst_addr === pd, "R10 dst hold", beat_dst_addr, pd);
         end
         if (idx == 1 && !poked) begin
            poked = 1;
            start = 1'b1;
            cfg_src_base = ~sb; cfg_dst_base = ~db;
            cfg_line_len = 12'd8; cfg_src_stride = 16'd4; cfg_total = 24'd4;
         end else begin
            start = 1'b0;
         end
         if (beat_ready) begin
            if (idx == 0) tag = (se || de) ? "R6" : "R2";
            else if (poked) tag = "R9";
            else if (len == 0) tag = "R5";
            else if ((idx * 4) % len == 0) tag = "R4";
            else tag = "R3";
            chk(beat_src_addr === exp_addr(s0, len, ss, idx), {tag, " src"},
                beat_src_addr, exp_addr(s0, len, ss, idx));
            chk(beat_dst_addr === exp_addr(d0, len, ds, idx), {tag, " dst"},
                beat_dst_addr, exp_addr(d0, len, ds, idx));
            idx++;
            held = 0;
         end else begin
            held = 1; ps = beat_src_addr; pd = beat_dst_addr;
         end
         @(negedge clk);
         guard++;
         if (idx == beats) begin
            chk(done === 1'b1, "R7 done", 32'(done), 32'd1);
            chk(busy === 1'b0, "R7 busy low", 32'(busy), 32'd0);
         end else begin
            chk(done === 1'b0, "R7 early done", 32'(done), 32'd0);
         end
      end
      if (guard >= 2000) chk(1'b0, "R7 hang", 32'(idx), 32'(beats));
      start = 1'b0; beat_ready = 1'b0;
      @(negedge clk);
      chk(done === 1'b0, "R7 one cycle", 32'(done), 32'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      int totals[3];
      totals[0] = 4; totals[1] = 20; totals[2] = 36;
      repeat (3) @(negedge clk);
      chk(busy === 1'b0, "R1 busy", 32'(busy), 32'd0);
      chk(beat_valid === 1'b0, "R1 valid", 32'(beat_valid), 32'd0);
      chk(done === 1'b0, "R1 done", 32'(done), 32'd0);
      chk(cfg_err === 1'b0, "R1 err", 32'(cfg_err), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy === 1'b0, "R1 idle after release", 32'(busy), 32'd0);

      cfg_pos_ofs = 32'hFFC1_234F;
      cfg_neg_ofs = 32'h8000_010B;
      for (int l = 0; l < 4; l++)
         for (int sx = 0; sx < 2; sx++)
            for (int ti = 0; ti < 3; ti++)
               for (int oc = 0; oc < 3; oc++) begin
                  int len, ss, ds;
                  len = l * 4;
                  ss = (l == 0) ? 8 + sx * 4 : len + sx * 4;
                  ds = (l == 0) ? 20 : len + (1 - sx) * 8;
                  run_cfg(32'h1000_0040 + 32'(l * 256), 32'hFFFF_FF00,
                          len, ss, ds, totals[ti], oc == 1, oc == 2, 0);
               end

      // R8 illegal setups
      run_cfg(32'h100, 32'h200, 8, 4, 16, 16, 0, 0, 1);   // line > src stride
      run_cfg(32'h100, 32'h200, 8, 16, 4, 16, 0, 0, 1);   // line > dst stride
      run_cfg(32'h100, 32'h200, 6, 16, 16, 16, 0, 0, 1);  // misaligned line
      run_cfg(32'h100, 32'h200, 8, 18, 16, 16, 0, 0, 1);  // misaligned stride
      run_cfg(32'h100, 32'h200, 8, 16, 16, 0, 0, 0, 1);   // zero total
      run_cfg(32'h100, 32'h200, 0, 3, 5, 10, 0, 0, 1);    // total not multiple of 4
      // R5 flat mode ignores an odd stride; R9 error clears on a legal start
      run_cfg(32'h300, 32'h400, 0, 3, 5, 12, 0, 0, 0);
      run_cfg(32'h300, 32'h400, 4, 4, 4, 8, 1, 1, 0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule